// File: doc/BRIEF.md
# Sparse Column Readout Sequencer

This block controls a pixel matrix that is wired only through shared lines. Each row has a row-reset line and a wired-OR row output. Each column has a column-reset line and a wired-OR column output. A pixel takes hits only while both its row-reset and its column-reset lines are high. The row OR outputs show the pixels of the columns whose column-reset line is high. A pixel is cleared when its column is the only column enabled and all row-reset lines are high.

While the block is acquiring, every line is driven high. A `frame_tick` pulse ends the event window. On that clock edge the block latches the column OR vector and freezes the matrix by dropping every row-reset line. It then visits only the flagged columns, lowest index first, in two cycles each. In the read cycle it enables that column alone with the row-reset lines low and captures the row OR bits. In the clear cycle it keeps that column alone enabled and raises every row-reset line, which clears the column. The word for the column is presented during that clear cycle. After the last flagged column the block pulses `frame_done` and returns the matrix to acquisition.

Top module: `sparse_col_readout`

## Requirements
- R1: Out of reset the block is acquiring: every bit of `row_rst_o` and `col_rst_o` is 1, and `word_valid_o` and `frame_done_o` are 0.
- R2: A `frame_tick` seen at a clock edge while acquiring latches `col_or_i` at that edge. If any latched bit is set, every `row_rst_o` bit is 0 in the next cycle.
- R3: In a read cycle, `row_rst_o` is all 0 and `col_rst_o` has exactly one bit set, the bit of the column being read.
- R4: Each read cycle is followed directly by a clear cycle. In it `row_rst_o` is all 1 and `col_rst_o` keeps the same single bit.
- R5: Only latched flagged columns are visited, each exactly once, in ascending index order. Columns without a flag are never enabled during readout.
- R6: `word_valid_o` is 1 only in clear cycles. In that cycle `word_col_o` is the column index as an unsigned binary number and `word_rows_o` bit r is the value of `row_or_i[r]` during the preceding read cycle.
- R7: For N latched columns, `frame_done_o` is 1 in the cycle that starts 2N clock edges after the sampling edge and is 0 before that within the frame. In that cycle both line vectors are again all 1.
- R8: From the sampling edge until `frame_done_o`, no column other than the one being cleared has its row-reset and column-reset lines high together. As a result, hits arriving during readout are not stored and do not appear in the next frame.
- R9: `frame_tick` is ignored while a frame is being read out. The frame still yields its N words and one `frame_done_o` pulse, and the block then stays acquiring.
- R10: If no `col_or_i` bit is set at the sampling edge, the frame ends with `frame_done_o` in the very next cycle. No word is produced and the lines never leave the acquiring state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Ends the event window and starts a frame |
| col_or_i | input | NCOLS | Wired-OR column outputs of the matrix |
| row_or_i | input | NROWS | Wired-OR row outputs of the matrix |
| row_rst_o | output | NROWS | Row-reset lines, 1 = connected |
| col_rst_o | output | NCOLS | Column-reset lines, 1 = enabled |
| word_valid_o | output | 1 | Column word valid |
| word_col_o | output | CW | Column index of the word |
| word_rows_o | output | NROWS | Row bits captured for that column |
| frame_done_o | output | 1 | One-cycle end-of-frame strobe |

## Verification
The hardest case is a hit arriving while the matrix is frozen. From the ports it looks like nothing happened, so the bench must force the pixel model to receive a hit in a read or clear cycle. The bench's behavioural matrix stores a hit only when the driven lines allow it. The bench injects a hit into an unflagged column in the middle of a readout. It then runs a second frame and requires that frame to produce no words. A stray `frame_tick` is also raised inside a busy frame, and the bench checks that the lines stay in acquisition after the done strobe.

// File: rtl/sro_pkg.sv
package sro_pkg;
  typedef enum logic [1:0] {
    PH_ACQ   = 2'd0,
    PH_READ  = 2'd1,
    PH_CLEAR = 2'd2
  } phase_e;
endpackage

// File: rtl/sro_pick.sv
module sro_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  // lowest set index wins
  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign idx = lowest_set(req);
  assign any = |req;
endmodule

// File: rtl/sro_ctrl.sv
module sro_ctrl
  import sro_pkg::*;
#(
  parameter int NCOLS = 16,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [NCOLS-1:0] col_or_i,
  input  logic [CW-1:0]    pick_idx,
  output phase_e           phase,
  output logic [NCOLS-1:0] pending,
  output logic [CW-1:0]    cur_q,
  output logic             frame_done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_ACQ;
      pending    <= '0;
      cur_q      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (phase)
        PH_ACQ: begin
          if (frame_tick) begin
            pending <= col_or_i;
            if (|col_or_i) phase <= PH_READ;
            else            frame_done <= 1'b1;
          end
        end
        PH_READ: begin
          pending[pick_idx] <= 1'b0;
          cur_q             <= pick_idx;
          phase             <= PH_CLEAR;
        end
        PH_CLEAR: begin
          if (|pending) phase <= PH_READ;
          else begin
            phase      <= PH_ACQ;
            frame_done <= 1'b1;
          end
        end
        default: phase <= PH_ACQ;
      endcase
    end
  end
endmodule

// File: rtl/sro_drive.sv
module sro_drive
  import sro_pkg::*;
#(
  parameter int NCOLS = 16,
  parameter int NROWS = 8,
  parameter int CW    = 4
) (
  input  phase_e           phase,
  input  logic [CW-1:0]    pick_idx,
  input  logic [CW-1:0]    cur_q,
  output logic [NROWS-1:0] row_rst_o,
  output logic [NCOLS-1:0] col_rst_o
);
  assign row_rst_o = {NROWS{phase != PH_READ}};

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    assign col_rst_o[c] = (phase == PH_ACQ)
                        | ((phase == PH_READ)  && (pick_idx == CW'(c)))
                        | ((phase == PH_CLEAR) && (cur_q    == CW'(c)));
  end
endmodule

// File: rtl/sparse_col_readout.sv
module sparse_col_readout
  import sro_pkg::*;
#(
  parameter  int NCOLS = 16,
  parameter  int NROWS = 8,
  localparam int CW    = (NCOLS > 1) ? $clog2(NCOLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [NCOLS-1:0] col_or_i,
  input  logic [NROWS-1:0] row_or_i,
  output logic [NROWS-1:0] row_rst_o,
  output logic [NCOLS-1:0] col_rst_o,
  output logic             word_valid_o,
  output logic [CW-1:0]    word_col_o,
  output logic [NROWS-1:0] word_rows_o,
  output logic             frame_done_o
);
  phase_e           phase;
  logic [NCOLS-1:0] pending;
  logic [CW-1:0]    pick_idx;
  logic [CW-1:0]    cur_q;
  logic             pick_any;

  // named events for the checker
  logic in_read, in_clear, busy;
  assign in_read  = (phase == PH_READ);
  assign in_clear = (phase == PH_CLEAR);
  assign busy     = in_read | in_clear;

  sro_pick #(.N(NCOLS), .IW(CW)) u_pick (
    .req(pending), .idx(pick_idx), .any(pick_any)
  );

  sro_ctrl #(.NCOLS(NCOLS), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .col_or_i(col_or_i),
    .pick_idx(pick_idx), .phase(phase), .pending(pending), .cur_q(cur_q),
    .frame_done(frame_done_o)
  );

  sro_drive #(.NCOLS(NCOLS), .NROWS(NROWS), .CW(CW)) u_drive (
    .phase(phase), .pick_idx(pick_idx), .cur_q(cur_q),
    .row_rst_o(row_rst_o), .col_rst_o(col_rst_o)
  );

  // word capture at the end of each read cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_valid_o <= 1'b0;
      word_col_o   <= '0;
      word_rows_o  <= '0;
    end else begin
      word_valid_o <= in_read & pick_any;
      if (in_read) begin
        word_col_o  <= pick_idx;
        word_rows_o <= row_or_i;
      end
    end
  end
endmodule

// File: rtl/sro_checker.sv
module sro_checker #(
  parameter int NCOLS = 16,
  parameter int NROWS = 8,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_tick,
  input logic             in_read,
  input logic             in_clear,
  input logic             busy,
  input logic [NROWS-1:0] row_rst_o,
  input logic [NCOLS-1:0] col_rst_o,
  input logic             word_valid_o,
  input logic [CW-1:0]    word_col_o,
  input logic             frame_done_o
);
  // R3: one column enabled during a read, matrix frozen
  a_r3_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_read |-> ($countones(col_rst_o) == 1) && (row_rst_o == '0));

  // R4: read is followed by clearing the same column
  a_r4_clear_same_col: assert property (@(posedge clk) disable iff (!rst_n)
    in_read |=> in_clear && (col_rst_o == $past(col_rst_o)) && (&row_rst_o));

  // R6: a word appears only right after a read, for the column being cleared
  a_r6_word_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(in_read) && col_rst_o[word_col_o]);

  // R5: words of one frame come out in ascending column order
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && $past(word_valid_o, 2)) |-> (word_col_o > $past(word_col_o, 2)));

  // R7: the done strobe comes with the matrix back in acquisition
  a_r7_done_acq: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> !busy && (&row_rst_o) && (&col_rst_o));

  // R8: no column other than the one being cleared is open during readout
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((&row_rst_o) ? ($countones(col_rst_o) == 1) : 1'b1));

  // R9: a tick during a read does not divert the sequence
  a_r9_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && frame_tick) |=> in_clear);
endmodule

bind sparse_col_readout sro_checker #(.NCOLS(NCOLS), .NROWS(NROWS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .in_read(in_read),
  .in_clear(in_clear), .busy(busy), .row_rst_o(row_rst_o), .col_rst_o(col_rst_o),
  .word_valid_o(word_valid_o), .word_col_o(word_col_o), .frame_done_o(frame_done_o)
);

// File: tb/tb_sparse_col_readout.sv
module tb_sparse_col_readout;
  localparam int NC = 16;
  localparam int NR = 8;
  localparam int CW = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic [NC-1:0] col_or;
  logic [NR-1:0] row_or;
  logic [NR-1:0] row_rst;
  logic [NC-1:0] col_rst;
  logic word_valid;
  logic [CW-1:0] word_col;
  logic [NR-1:0] word_rows;
  logic frame_done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // behavioural pixel matrix
  logic [NR-1:0] pix [NC];
  logic [NR-1:0] inj [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  sparse_col_readout #(.NCOLS(NC), .NROWS(NR)) dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .col_or_i(col_or),
    .row_or_i(row_or), .row_rst_o(row_rst), .col_rst_o(col_rst),
    .word_valid_o(word_valid), .word_col_o(word_col), .word_rows_o(word_rows),
    .frame_done_o(frame_done)
  );

  always_comb begin
    for (int c = 0; c < NC; c++) col_or[c] = |pix[c];
    for (int r = 0; r < NR; r++) begin
      row_or[r] = 1'b0;
      for (int c = 0; c < NC; c++) row_or[r] = row_or[r] | (pix[c][r] & col_rst[c]);
    end
  end

  always @(posedge clk) begin
    for (int c = 0; c < NC; c++) begin
      if (!rst_n) pix[c] <= '0;
      else if ((col_rst == (NC'(1) << c)) && (&row_rst)) pix[c] <= '0;
      else pix[c] <= pix[c] | (inj[c] & row_rst & {NR{col_rst[c]}});
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hit(input int c, input int r);
    @(negedge clk);
    inj[c][r] = 1'b1;
    @(negedge clk);
    inj[c][r] = 1'b0;
  endtask

  // Runs one frame; returns the number of words expected from the model.
  task automatic run_frame(input int dist_cycle, input int dist_col, input int dist_row,
                           input int tick_cycle, output int n);
    int ec [NC];
    logic [NR-1:0] er [NC];
    n = 0;
    for (int c = 0; c < NC; c++) begin
      if (|pix[c]) begin
        ec[n] = c;
        er[n] = pix[c];
        n++;
      end
    end
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    for (int i = 0; i <= 2 * n; i++) begin
      if (i < 2 * n) begin
        chk("R7 done low mid-frame", 64'(frame_done), 64'(0));
        chk("R3/R4 single column", 64'(col_rst), 64'(1) << ec[i / 2]);
        if (i % 2 == 0) begin
          chk("R2/R3 frozen rows in read", 64'(row_rst), 64'(0));
          chk("R6 no word in read", 64'(word_valid), 64'(0));
        end else begin
          chk("R4 rows high in clear", 64'(row_rst), 64'({NR{1'b1}}));
          chk("R6 word valid", 64'(word_valid), 64'(1));
          chk("R5 word column order", 64'(word_col), 64'(ec[i / 2]));
          chk("R6 word rows", 64'(word_rows), 64'(er[i / 2]));
        end
      end else begin
        chk("R7 done at 2N", 64'(frame_done), 64'(1));
        chk("R7 rows back", 64'(row_rst), 64'({NR{1'b1}}));
        chk("R7 cols back", 64'(col_rst), 64'({NC{1'b1}}));
        chk("R6 no word at done", 64'(word_valid), 64'(0));
      end
      if (i == dist_cycle) inj[dist_col][dist_row] = 1'b1;
      if (i == tick_cycle) frame_tick = 1'b1;
      @(negedge clk);
      for (int c = 0; c < NC; c++) inj[c] = '0;
      frame_tick = 1'b0;
    end
    for (int k = 0; k < 3; k++) begin
      chk("R9 stays acquiring", 64'(row_rst), 64'({NR{1'b1}}));
      chk("R9 no extra word", 64'(word_valid), 64'(0));
      chk("R9 no extra done", 64'(frame_done), 64'(0));
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 rows after reset", 64'(row_rst), 64'({NR{1'b1}}));
    chk("R1 cols after reset", 64'(col_rst), 64'({NC{1'b1}}));
    chk("R1 no word", 64'(word_valid), 64'(0));
    chk("R1 no done", 64'(frame_done), 64'(0));
  endtask

  task automatic t_empty();
    int n;
    run_frame(-1, 0, 0, -1, n);
    chk("R10 empty frame count", 64'(n), 64'(0));
  endtask

  task automatic t_single();
    int n;
    hit(3, 1); hit(3, 5);
    run_frame(-1, 0, 0, -1, n);
    chk("R5 single column count", 64'(n), 64'(1));
  endtask

  task automatic t_edges();
    int n;
    hit(15, 7); hit(0, 0); hit(7, 3); hit(7, 4);
    run_frame(-1, 0, 0, -1, n);
    chk("R5 edge columns count", 64'(n), 64'(3));
  endtask

  task automatic t_full_col();
    int n;
    for (int r = 0; r < NR; r++) hit(9, r);
    hit(2, 6);
    run_frame(-1, 0, 0, -1, n);
    chk("R6 full column count", 64'(n), 64'(2));
  endtask

  task automatic t_frozen();
    int n;
    hit(4, 2); hit(10, 6);
    run_frame(0, 12, 3, -1, n);
    chk("R8 frame before stray hit", 64'(n), 64'(2));
    hit(5, 1);
    run_frame(1, 6, 0, -1, n);
    run_frame(-1, 0, 0, -1, n);
    chk("R8 stray hits not stored", 64'(n), 64'(0));
  endtask

  task automatic t_busy_tick();
    int n;
    hit(1, 1); hit(5, 5); hit(6, 0);
    run_frame(-1, 0, 0, 2, n);
    chk("R9 busy tick frame count", 64'(n), 64'(3));
  endtask

  task automatic t_all_cols();
    int n;
    for (int c = 0; c < NC; c++) hit(c, c % NR);
    run_frame(-1, 0, 0, 5, n);
    chk("R5 all columns count", 64'(n), 64'(NC));
  endtask

  initial begin
    for (int c = 0; c < NC; c++) inj[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_single();
    t_edges();
    t_full_col();
    t_frozen();
    t_busy_tick();
    t_all_cols();
    t_empty();
    summary();
    $finish;
  end
endmodule